// File: doc/BRIEF.md
# Modified Floating Point Charge Linearizer

This block turns each digitized sample from a multi-range charge-integrating front end into a linear charge value. A sample has a 2-bit range exponent and a 5-bit mantissa from a non-uniform flash converter. It also carries a 2-bit capacitor tag.

Within one range, the 32 mantissa codes fall into five sections. From the lowest code upward the sections hold 7, 6, 6, 6 and 7 codes, and their bins are 1, 2, 3, 4 and 5 base bins wide. One range therefore spans 96 base bins. Each step up in range multiplies the bin size by 5. Each range also starts where the range below it ended, not at zero. The block undoes both of these effects. It reports the centre of the selected bin, applies a per-range slope and offset correction, and delivers the result two clocks after the sample.

The output unit is half of the calibration-mode least count, which is one third of a fC. In normal mode each base bin is 1 fC, so the nominal value is three times larger than in calibration mode.

Top module: `qlin_top`

## Requirements
- R1: With default calibration, range 0 in calibration mode (`cal_mode`=1) gives out_q = 2·p + w, where p is the bin start in base bins and w is the bin width. Mantissa 0 gives 1.
- R2: Sections start at mantissa codes 0, 7, 13, 19 and 25, with bin widths 1, 2, 3, 4 and 5 base bins. In normal mode, range 0 codes 6, 7, 12 and 13 give 39, 48, 108 and 123.
- R3: Range R begins where range R-1 ends. The lower ranges add starting offsets of 96, 576 and 2976 base bins. In calibration mode, range 0 code 31 gives 187, range 1 code 0 gives 197, and range 3 code 31 gives 29327.
- R4: In range R every bin is 5^R times its range-0 width. In normal mode, range 1 codes 0 and 1 differ by 30, and range 2 code 0 gives 3531.
- R5: Normal mode (`cal_mode`=0) gives exactly three times the calibration-mode value for the same code. For example, range 1 code 0 gives 591 against 197.
- R6: Every sample with `in_valid`=1 produces exactly one `out_valid`=1 two clock edges later. A cycle with `in_valid`=0 produces `out_valid`=0 two edges later, whatever the data inputs hold.
- R7: `out_cap` equals the `in_cap` of the sample that produced the result.
- R8: After reset, `out_valid` and `out_q` are 0. Every range has slope 256 (1.0) and offset 0.
- R9: A write with `cfg_we`=1 sets a calibration constant. `cfg_addr[2]`=0 selects the slope and 1 selects the offset. `cfg_addr[1:0]` selects the range. The slope is unsigned with 8 fractional bits, taken from `cfg_wdata[11:0]`. The offset is signed, taken from `cfg_wdata[15:0]`. The result is out_q = floor(nominal·slope/256) + offset, and only the addressed range is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_exp | input | 2 | Range exponent |
| in_mant | input | 5 | Non-uniform mantissa code |
| in_cap | input | 2 | Capacitor tag carried with the sample |
| cal_mode | input | 1 | 1: base bin of 1/3 fC; 0: base bin of 1 fC |
| cfg_we | input | 1 | Calibration write strobe |
| cfg_addr | input | 3 | Bit 2 selects offset (1) or slope (0); bits 1:0 select the range |
| cfg_wdata | input | 16 | Calibration write data |
| out_valid | output | 1 | Result qualifier |
| out_q | output | 22 | Signed linear charge in sixths of a fC |
| out_cap | output | 2 | Capacitor tag of the result |

## Verification
Single samples at the section edges of range 0 distinguish the section widths from a uniform mantissa. The last code of one range followed by the first code of the next distinguishes offset ranges from ranges that all restart at zero. Each of the 128 codes is swept back to back in both modes against a behavioural model; this catches errors in the gain power, the mode factor and the pipeline alignment under full throughput. Calibration writes to a single range, followed by samples from that range and a neighbouring one, show that the correction lands on the addressed range alone.

// File: rtl/qlin_pkg.sv
`timescale 1ns/1ps
package qlin_pkg;
  localparam int EXP_W      = 2;
  localparam int MANT_W     = 5;
  localparam int CAP_W      = 2;
  localparam int N_RANGE    = 1 << EXP_W;
  localparam int N_SEC      = 5;
  localparam int GAIN       = 5;
  localparam int NOM_W      = 17;
  localparam int SLOPE_W    = 12;
  localparam int SLOPE_FRAC = 8;
  localparam int OFS_W      = 16;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = EXP_W + 1;
  localparam int OUT_W      = NOM_W + SLOPE_W - SLOPE_FRAC + 1;

  // number of codes in section s (outer sections one code longer)
  function automatic int sec_len(input int s);
    return (s == 0 || s == N_SEC - 1) ? 7 : 6;
  endfunction

  // first mantissa code of section s
  function automatic int sec_first(input int s);
    int acc = 0;
    for (int k = 0; k < s; k++) acc += sec_len(k);
    return acc;
  endfunction

  // bin position (base bins) where section s begins
  function automatic int sec_start(input int s);
    int acc = 0;
    for (int k = 0; k < s; k++) acc += sec_len(k) * (k + 1);
    return acc;
  endfunction

  function automatic int range_span();
    return sec_start(N_SEC);
  endfunction

  function automatic int pow_gain(input int r);
    int g = 1;
    for (int k = 0; k < r; k++) g *= GAIN;
    return g;
  endfunction

  // base-bin position where range r begins
  function automatic int range_first(input int r);
    int acc = 0;
    for (int k = 0; k < r; k++) acc += range_span() * pow_gain(k);
    return acc;
  endfunction
endpackage

// File: rtl/qlin_decode.sv
`timescale 1ns/1ps
module qlin_decode
  import qlin_pkg::*;
#(
  parameter int P_EXP_W  = EXP_W,
  parameter int P_MANT_W = MANT_W,
  parameter int P_NOM_W  = NOM_W
) (
  input  logic [P_EXP_W-1:0]  exp_i,
  input  logic [P_MANT_W-1:0] mant_i,
  input  logic                cal_mode_i,
  output logic [P_NOM_W-1:0]  nom_o
);
  localparam int NR = 1 << P_EXP_W;

  int w, first, sstart, g, rbase, pos2, half_units;

  always_comb begin
    w = 1; first = 0; sstart = 0;
    for (int s = 0; s < N_SEC; s++) begin
      if (int'(mant_i) >= sec_first(s)) begin
        w      = s + 1;
        first  = sec_first(s);
        sstart = sec_start(s);
      end
    end
    g = 1; rbase = 0;
    for (int r = 0; r < NR; r++) begin
      if (int'(exp_i) == r) begin
        g     = pow_gain(r);
        rbase = range_first(r);
      end
    end
    // bin centre in half base bins
    pos2       = 2 * (sstart + (int'(mant_i) - first) * w) + w;
    half_units = 2 * rbase + g * pos2;
    nom_o      = cal_mode_i ? P_NOM_W'(half_units) : P_NOM_W'(3 * half_units);
  end
endmodule

// File: rtl/qlin_calbank.sv
`timescale 1ns/1ps
module qlin_calbank
  import qlin_pkg::*;
#(
  parameter int P_EXP_W   = EXP_W,
  parameter int P_SLOPE_W = SLOPE_W,
  parameter int P_OFS_W   = OFS_W,
  parameter int P_DATA_W  = DATA_W,
  parameter int P_FRAC    = SLOPE_FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [P_EXP_W:0]     addr_i,
  input  logic [P_DATA_W-1:0]  wdata_i,
  input  logic [P_EXP_W-1:0]   rd_range_i,
  output logic [P_SLOPE_W-1:0] slope_o,
  output logic [P_OFS_W-1:0]   ofs_o
);
  localparam int NR = 1 << P_EXP_W;
  localparam logic [P_SLOPE_W-1:0] UNITY = P_SLOPE_W'(1 << P_FRAC);

  logic [P_SLOPE_W-1:0] slope_q [NR];
  logic [P_OFS_W-1:0]   ofs_q   [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NR; r++) begin
        slope_q[r] <= UNITY;
        ofs_q[r]   <= '0;
      end
    end else if (we_i) begin
      if (addr_i[P_EXP_W]) ofs_q[addr_i[P_EXP_W-1:0]]   <= wdata_i[P_OFS_W-1:0];
      else                 slope_q[addr_i[P_EXP_W-1:0]] <= wdata_i[P_SLOPE_W-1:0];
    end
  end

  assign slope_o = slope_q[rd_range_i];
  assign ofs_o   = ofs_q[rd_range_i];
endmodule

// File: rtl/qlin_scale.sv
`timescale 1ns/1ps
module qlin_scale
  import qlin_pkg::*;
#(
  parameter int P_NOM_W   = NOM_W,
  parameter int P_SLOPE_W = SLOPE_W,
  parameter int P_FRAC    = SLOPE_FRAC,
  parameter int P_OFS_W   = OFS_W,
  parameter int P_OUT_W   = OUT_W
) (
  input  logic [P_NOM_W-1:0]   nom_i,
  input  logic [P_SLOPE_W-1:0] slope_i,
  input  logic [P_OFS_W-1:0]   ofs_i,
  output logic [P_OUT_W-1:0]   q_o
);
  localparam int PW = P_NOM_W + P_SLOPE_W;

  logic [PW-1:0]         prod;
  logic [PW-P_FRAC-1:0]  scaled;

  assign prod   = {{P_SLOPE_W{1'b0}}, nom_i} * {{P_NOM_W{1'b0}}, slope_i};
  assign scaled = prod[PW-1:P_FRAC];
  assign q_o    = {{(P_OUT_W-(PW-P_FRAC)){1'b0}}, scaled}
                + {{(P_OUT_W-P_OFS_W){ofs_i[P_OFS_W-1]}}, ofs_i};
endmodule

// File: rtl/qlin_top.sv
`timescale 1ns/1ps
module qlin_top
  import qlin_pkg::*;
#(
  parameter int P_EXP_W  = EXP_W,
  parameter int P_MANT_W = MANT_W,
  parameter int P_CAP_W  = CAP_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_OUT_W  = OUT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [P_EXP_W-1:0]         in_exp,
  input  logic [P_MANT_W-1:0]        in_mant,
  input  logic [P_CAP_W-1:0]         in_cap,
  input  logic                       cal_mode,
  input  logic                       cfg_we,
  input  logic [P_EXP_W:0]           cfg_addr,
  input  logic [P_DATA_W-1:0]        cfg_wdata,
  output logic                       out_valid,
  output logic signed [P_OUT_W-1:0]  out_q,
  output logic [P_CAP_W-1:0]         out_cap
);
  logic [NOM_W-1:0]   nom_d, s1_nom;
  logic [P_EXP_W-1:0] s1_exp;
  logic [P_CAP_W-1:0] s1_cap;
  logic               s1_valid;
  logic [SLOPE_W-1:0] slope;
  logic [OFS_W-1:0]   ofs;
  logic [P_OUT_W-1:0] q_d;

  qlin_decode #(.P_EXP_W(P_EXP_W), .P_MANT_W(P_MANT_W), .P_NOM_W(NOM_W)) u_dec (
    .exp_i(in_exp), .mant_i(in_mant), .cal_mode_i(cal_mode), .nom_o(nom_d)
  );

  // stage 1: nominal decode
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_nom   <= '0;
      s1_exp   <= '0;
      s1_cap   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_nom   <= nom_d;
      s1_exp   <= in_exp;
      s1_cap   <= in_cap;
    end
  end

  qlin_calbank #(.P_EXP_W(P_EXP_W), .P_DATA_W(P_DATA_W)) u_cal (
    .clk(clk), .rst(rst), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .rd_range_i(s1_exp), .slope_o(slope), .ofs_o(ofs)
  );

  qlin_scale #(.P_OUT_W(P_OUT_W)) u_scl (
    .nom_i(s1_nom), .slope_i(slope), .ofs_i(ofs), .q_o(q_d)
  );

  // stage 2: calibrated result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_q     <= '0;
      out_cap   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_q     <= q_d;
      out_cap   <= s1_cap;
    end
  end
endmodule

// File: rtl/qlin_chk.sv
`timescale 1ns/1ps
module qlin_chk #(
  parameter int P_CAP_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [P_CAP_W-1:0] in_cap,
  input logic               out_valid,
  input logic [P_CAP_W-1:0] out_cap
);
  AST_VALID_TWO_LATE: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid); // R6
  AST_IDLE_TWO_LATE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid); // R6
  AST_CAP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 (out_cap == $past(in_cap, 2))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_valid); // R8
endmodule

bind qlin_top qlin_chk #(.P_CAP_W(P_CAP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_cap(in_cap),
  .out_valid(out_valid), .out_cap(out_cap)
);

// File: tb/tb_qlin_top.sv
`timescale 1ns/1ps
module tb_qlin_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_exp = '0;
  logic [4:0] in_mant = '0;
  logic [1:0] in_cap = '0;
  logic cal_mode = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic out_valid;
  logic signed [21:0] out_q;
  logic [1:0] out_cap;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  qlin_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_exp(in_exp), .in_mant(in_mant),
    .in_cap(in_cap), .cal_mode(cal_mode), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_q(out_q), .out_cap(out_cap)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // ---- behavioural reference ----
  function automatic int bin_w(input int c);
    if (c < 7) return 1;
    if (c < 13) return 2;
    if (c < 19) return 3;
    if (c < 25) return 4;
    return 5;
  endfunction

  function automatic int ref_nom(input int e, input int m, input int mode);
    int span = 0, pos = 0, start = 0, g = 1, v;
    for (int c = 0; c < 32; c++) span += bin_w(c);
    for (int c = 0; c < m; c++) pos += bin_w(c);
    for (int r = 0; r < e; r++) begin start += span * g; g *= 5; end
    v = 2 * start + g * (2 * pos + bin_w(m));
    return mode ? v : 3 * v;
  endfunction

  int slope_m[4];
  int ofs_m[4];
  bit mv1, mv2;
  int mq1, mq2, me1, mc1, mc2;
  string cur_tag = "R6";
  string mt1, mt2;

  always @(posedge clk) begin
    if (rst) begin
      mv1 = 0; mv2 = 0;
      for (int r = 0; r < 4; r++) begin slope_m[r] = 256; ofs_m[r] = 0; end
    end else begin
      mv2 = mv1; mc2 = mc1; mt2 = mt1;
      if (mv1) mq2 = (mq1 * slope_m[me1]) / 256 + ofs_m[me1];
      mv1 = in_valid;
      mq1 = ref_nom(int'(in_exp), int'(in_mant), int'(cal_mode));
      me1 = int'(in_exp); mc1 = int'(in_cap); mt1 = cur_tag;
      if (cfg_we) begin
        if (cfg_addr[2]) ofs_m[cfg_addr[1:0]] = int'($signed(cfg_wdata));
        else slope_m[cfg_addr[1:0]] = int'(cfg_wdata[11:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == mv2, "R6 valid", int'(out_valid), int'(mv2));
      if (mv2 && out_valid) begin
        chk(int'(out_q) == mq2, mt2, int'(out_q), mq2);
        chk(int'(out_cap) == mc2, "R7 cap", int'(out_cap), mc2);
      end
    end
  end

  // ---- stimulus helpers ----
  task automatic one(input int e, input int m, input bit mode, input int expv, input string tag);
    @(negedge clk);
    cur_tag = tag; in_valid = 1; in_exp = 2'(e); in_mant = 5'(m); cal_mode = mode;
    in_cap = 2'(m);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 1'b1 && int'(out_q) == expv, tag, int'(out_q), expv);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  int a0, a1;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    chk(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    chk(int'(out_q) == 0, "R8 out_q", int'(out_q), 0);
    one(0, 0, 1, 1, "R1 r0 code0");
    one(0, 0, 0, 3, "R8 default cal");
    one(0, 6, 0, 39, "R2 code6");
    one(0, 7, 0, 48, "R2 code7");
    one(0, 12, 0, 108, "R2 code12");
    one(0, 13, 0, 123, "R2 code13");
    one(0, 31, 1, 187, "R3 r0 top");
    one(1, 0, 1, 197, "R3 r1 bottom");
    one(3, 31, 1, 29327, "R3 r3 top");
    one(1, 0, 0, 591, "R5 normal x3");
    one(2, 0, 0, 3531, "R4 r2 code0");
    one(1, 1, 0, 621, "R4 r1 code1");
    a0 = 591; a1 = 621;
    chk(a1 - a0 == 30, "R4 step", a1 - a0, 30);
    // R6: idle cycles with busy data produce no output
    @(negedge clk);
    in_valid = 0; in_exp = 2'd3; in_mant = 5'd17;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R6 idle", int'(out_valid), 0);
    // R9 calibration: slope 2.0 and offset -100 on range 1
    wr(3'b001, 512);
    wr(3'b101, -100);
    one(1, 0, 0, 1082, "R9 r1 cal");
    one(0, 0, 0, 3, "R9 r0 untouched");
    wr(3'b100, 10);
    one(0, 0, 0, 13, "R9 r0 offset");
    one(2, 0, 0, 3531, "R9 r2 untouched");
    // full sweep, back to back, both modes (R1 R3 R4 R5 via model)
    for (int md = 0; md < 2; md++) begin
      for (int e = 0; e < 4; e++) begin
        for (int m = 0; m < 32; m++) begin
          @(negedge clk);
          cur_tag = "R4 sweep"; in_valid = 1; in_exp = 2'(e); in_mant = 5'(m);
          cal_mode = md[0]; in_cap = 2'(m + e);
        end
      end
    end
    @(negedge clk);
    in_valid = 0;
    repeat (4) @(negedge clk);
    // R8 again: reset restores defaults
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    one(1, 0, 0, 591, "R8 cal restored");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule